// File: doc/BRIEF.md
# Two-Phase Segmented Ternary Match Array

This block is a ternary content-addressable store. It holds a number of words, and each word is made of ternary cells. A search key is compared against every word at once, in two clocked phases. Phase one compares only a short gating segment of each word, which by default is its most significant cells. Only words whose gating segment matched in full are considered in phase two, where the remaining cells are compared. This follows how prefix tables behave: most losing entries differ from the key in their leading bits, so few words ever need their long tail evaluated.

Entries are loaded through a write port that takes a word address and a pattern of two bits per cell. A write waits while a search is in flight. When a search finishes, a one-cycle done pulse is raised. With it come three results: a hit flag, the index of the matching word with the lowest address, and the number of words that passed phase one. Software keeps the table sorted so that the most specific entry has the lowest address. The lowest matching index is therefore the preferred match.

Top module: `tcam_two_phase`

## Requirements
- R1: Cell encoding, with the upper bit of each cell pair first:
  - `01` matches only a key bit of 0.
  - `10` matches only a key bit of 1.
  - `00` matches either key bit.
  - `11` matches nothing.
  - Cell c occupies pattern bits [2c+1:2c], and key bit c is compared with it.
- R2: After reset every stored word holds the `11` code in all cells, so no word can match. The outputs are done=0, hit=0, hit_idx=0, act_cnt=0 and wr_ready=1.
- R3: The gating segment is cells SEG1_HI down to SEG1_LO (by default the 8 most significant of 32). act_cnt equals the number of words whose gating-segment cells all match the key.
- R4: A word matches only if its gating segment matches and its remaining cells also match. A word whose gating segment fails never matches, even if all its other cells agree with the key.
- R5: hit is 1 exactly when at least one word matches. hit_idx is then the lowest matching word index, and it is 0 when there is no hit.
- R6: A search is accepted on a clock edge at which srch_start=1 and the block is idle. done is high for exactly one cycle, the fourth cycle after that edge. hit, hit_idx and act_cnt change only as done rises, and they hold until the next done.
- R7: srch_start is ignored from the accepting edge through the done cycle. Neither the key in use nor the number of done pulses is affected.
- R8: A write is applied on an edge where wr_en=1 and wr_ready=1. A search accepted on the next edge sees the new word. Addresses at or above WORDS are dropped.
- R9: wr_ready is 0 while a search is in flight (accepting edge through the done cycle). It is also 0 in an idle cycle where srch_start=1: when both requests arrive together, the search goes first and compares the old contents, and the write is applied after done.
- R10: The gating segment may be placed anywhere inside the word by parameter, for example a middle band. act_cnt and hit then follow that placement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request, held until accepted |
| wr_addr | input | $clog2(WORDS) | Word index to write |
| wr_pat | input | 2*CELLS | Cell codes, two bits per cell |
| wr_ready | output | 1 | Write is accepted on this edge when high |
| srch_start | input | 1 | Search request |
| srch_key | input | CELLS | Search key, sampled at acceptance |
| done | output | 1 | One-cycle result-valid pulse |
| hit | output | 1 | At least one word matched |
| hit_idx | output | $clog2(WORDS) | Lowest matching word index |
| act_cnt | output | $clog2(WORDS+1) | Words that passed the gating segment |

## Verification
A write request and a search request can arrive in the same idle cycle. The bench provokes this by raising wr_en and srch_start together, using a pattern that would change the result of that very search. It judges the outcome on three points. First, wr_ready must read low in that cycle. Second, the search result must equal the value computed from the old table. Third, a second search with the same key must show the new entry, which proves that the stalled write landed afterwards. The bench also keeps srch_start high during a search with a different key, and checks that the result still belongs to the first key and that no extra done appears.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PH1  = 3'd1,
    ST_PH2  = 3'd2,
    ST_RES  = 3'd3,
    ST_OUT  = 3'd4
  } tcam_st_e;

  localparam logic [1:0] CODE_ANY  = 2'b00;
  localparam logic [1:0] CODE_ZERO = 2'b01;
  localparam logic [1:0] CODE_ONE  = 2'b10;
  localparam logic [1:0] CODE_NONE = 2'b11;

  // One ternary cell against one key bit.
  function automatic logic cell_hit(input logic [1:0] code, input logic kb);
    logic r;
    case (code)
      CODE_ANY:  r = 1'b1;
      CODE_ZERO: r = ~kb;
      CODE_ONE:  r = kb;
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tcam_row.sv
module tcam_row
  import tcam_pkg::*;
#(
  parameter int CELLS   = 32,
  parameter int SEG1_HI = 31,
  parameter int SEG1_LO = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [2*CELLS-1:0] wpat,
  input  logic [CELLS-1:0]   key,
  input  logic               clr,
  input  logic               ev1,
  input  logic               ev2,
  output logic               m1,
  output logic               m2
);

  localparam logic [CELLS-1:0] ALL1      = '1;
  localparam logic [CELLS-1:0] SEG1_MASK = (ALL1 >> (CELLS - 1 - SEG1_HI)) & (ALL1 << SEG1_LO);

  logic [2*CELLS-1:0] pat_q, pat_d;
  logic               m1_q, m1_d, m2_q, m2_d;
  logic [CELLS-1:0]   ok;
  logic               pre_ok, suf_ok;

  genvar c;
  generate
    for (c = 0; c < CELLS; c++) begin : g_cell
      assign ok[c] = cell_hit(pat_q[2*c +: 2], key[c]);
    end
  endgenerate

  assign pre_ok = &(ok | ~SEG1_MASK);
  assign suf_ok = &(ok | SEG1_MASK);

  always_comb begin
    pat_d = pat_q;
    if (we) pat_d = wpat;
    m1_d = m1_q;
    if (clr)      m1_d = 1'b0;
    else if (ev1) m1_d = pre_ok;
    m2_d = m2_q;
    if (clr)      m2_d = 1'b0;
    else if (ev2) m2_d = m1_q & suf_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q <= '1;
      m1_q  <= 1'b0;
      m2_q  <= 1'b0;
    end else begin
      pat_q <= pat_d;
      m1_q  <= m1_d;
      m2_q  <= m2_d;
    end
  end

  assign m1 = m1_q;
  assign m2 = m2_q;

endmodule

// File: rtl/tcam_prio.sv
module tcam_prio #(
  parameter int N  = 64,
  parameter int AW = 6
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [AW-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = AW'(i);
    end
  end

  assign any = |req;

endmodule

// File: rtl/tcam_popcnt.sv
module tcam_popcnt #(
  parameter int N  = 64,
  parameter int CW = 7
) (
  input  logic [N-1:0]  v,
  output logic [CW-1:0] cnt
);

  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) begin
      cnt = cnt + CW'(v[i]);
    end
  end

endmodule

// File: rtl/tcam_ctrl.sv
module tcam_ctrl
  import tcam_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic wr_req,
  output logic key_ld,
  output logic ev1,
  output logic ev2,
  output logic ld_res,
  output logic done,
  output logic busy,
  output logic wr_go,
  output logic wr_ready
);

  tcam_st_e st_q, st_d;
  logic     idle;

  assign idle     = (st_q == ST_IDLE);
  assign key_ld   = idle & start;
  assign wr_ready = idle & ~start;
  assign wr_go    = wr_req & wr_ready;
  assign ev1      = (st_q == ST_PH1);
  assign ev2      = (st_q == ST_PH2);
  assign ld_res   = (st_q == ST_RES);
  assign done     = (st_q == ST_OUT);
  assign busy     = ~idle;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (start) st_d = ST_PH1;
      ST_PH1:  st_d = ST_PH2;
      ST_PH2:  st_d = ST_RES;
      ST_RES:  st_d = ST_OUT;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/tcam_two_phase.sv
module tcam_two_phase #(
  parameter int WORDS   = 64,
  parameter int CELLS   = 32,
  parameter int SEG1_HI = 31,
  parameter int SEG1_LO = 24,
  localparam int AW     = $clog2(WORDS),
  localparam int CW     = $clog2(WORDS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [2*CELLS-1:0] wr_pat,
  output logic               wr_ready,
  input  logic               srch_start,
  input  logic [CELLS-1:0]   srch_key,
  output logic               done,
  output logic               hit,
  output logic [AW-1:0]      hit_idx,
  output logic [CW-1:0]      act_cnt
);

  logic             key_ld, ev1, ev2, ld_res, busy, wr_go;
  logic [CELLS-1:0] key_q, key_d;
  logic [WORDS-1:0] m1_v, m2_v;
  logic             any_w;
  logic [AW-1:0]    idx_w;
  logic [CW-1:0]    cnt_w;
  logic             hit_q, hit_d;
  logic [AW-1:0]    idx_q, idx_d;
  logic [CW-1:0]    cnt_q, cnt_d;

  tcam_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(srch_start), .wr_req(wr_en),
    .key_ld(key_ld), .ev1(ev1), .ev2(ev2), .ld_res(ld_res),
    .done(done), .busy(busy), .wr_go(wr_go), .wr_ready(wr_ready)
  );

  genvar w;
  generate
    for (w = 0; w < WORDS; w++) begin : g_word
      logic we_w;
      assign we_w = wr_go & (wr_addr == AW'(w));
      tcam_row #(.CELLS(CELLS), .SEG1_HI(SEG1_HI), .SEG1_LO(SEG1_LO)) u_row (
        .clk(clk), .rst_n(rst_n), .we(we_w), .wpat(wr_pat), .key(key_q),
        .clr(key_ld), .ev1(ev1), .ev2(ev2), .m1(m1_v[w]), .m2(m2_v[w])
      );
    end
  endgenerate

  tcam_prio #(.N(WORDS), .AW(AW)) u_prio (.req(m2_v), .any(any_w), .idx(idx_w));
  tcam_popcnt #(.N(WORDS), .CW(CW)) u_pop (.v(m1_v), .cnt(cnt_w));

  always_comb begin
    key_d = key_q;
    if (key_ld) key_d = srch_key;
    hit_d = hit_q;
    idx_d = idx_q;
    cnt_d = cnt_q;
    if (ld_res) begin
      hit_d = any_w;
      idx_d = idx_w;
      cnt_d = cnt_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
      hit_q <= 1'b0;
      idx_q <= '0;
      cnt_q <= '0;
    end else begin
      key_q <= key_d;
      hit_q <= hit_d;
      idx_q <= idx_d;
      cnt_q <= cnt_d;
    end
  end

  assign hit     = hit_q;
  assign hit_idx = idx_q;
  assign act_cnt = cnt_q;

endmodule

// File: rtl/tcam_chk.sv
module tcam_chk #(
  parameter int WORDS = 64,
  localparam int AW   = $clog2(WORDS),
  localparam int CW   = $clog2(WORDS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          wr_ready,
  input logic          srch_start,
  input logic          done,
  input logic          hit,
  input logic [AW-1:0] hit_idx,
  input logic [CW-1:0] act_cnt
);

  logic [2:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lat_q <= 3'd0;
    else if (busy) lat_q <= lat_q + 3'd1;
    else           lat_q <= 3'd0;
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) done |-> lat_q == 3'd3); // R6
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable({hit, hit_idx, act_cnt})); // R6
  AST_NOHIT_IDX: assert property (@(posedge clk) disable iff (!rst_n) (done && !hit) |-> hit_idx == '0); // R5
  AST_HIT_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n) (done && hit) |-> act_cnt != '0); // R4
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) act_cnt <= CW'(WORDS)); // R3
  AST_NO_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !wr_ready); // R9
  AST_START_WINS: assert property (@(posedge clk) disable iff (!rst_n) srch_start |-> !wr_ready); // R9

endmodule

bind tcam_two_phase tcam_chk #(.WORDS(WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wr_ready(wr_ready),
  .srch_start(srch_start), .done(done), .hit(hit), .hit_idx(hit_idx),
  .act_cnt(act_cnt)
);

// File: tb/sim_tcam_two_phase.sv
module sim_tcam_two_phase;

  localparam int W  = 8;
  localparam int C  = 4;
  localparam int AW = 3;
  localparam int CW = 4;

  logic          clk, rst_n;
  logic          wr_en, srch_start;
  logic [AW-1:0] wr_addr;
  logic [2*C-1:0] wr_pat;
  logic [C-1:0]  srch_key;
  logic          rdy0, done0, hit0, rdy1, done1, hit1;
  logic [AW-1:0] idx0, idx1;
  logic [CW-1:0] cnt0, cnt1;

  int total = 0;
  int bad   = 0;
  logic [2*C-1:0] mem [W];

  // Main instance: gating segment = cells 3..2 (top). Second: cells 2..1 (middle band).
  tcam_two_phase #(.WORDS(W), .CELLS(C), .SEG1_HI(3), .SEG1_LO(2)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_pat(wr_pat),
    .wr_ready(rdy0), .srch_start(srch_start), .srch_key(srch_key), .done(done0),
    .hit(hit0), .hit_idx(idx0), .act_cnt(cnt0));

  tcam_two_phase #(.WORDS(W), .CELLS(C), .SEG1_HI(2), .SEG1_LO(1)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_pat(wr_pat),
    .wr_ready(rdy1), .srch_start(srch_start), .srch_key(srch_key), .done(done1),
    .hit(hit1), .hit_idx(idx1), .act_cnt(cnt1));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit cell_ok(input logic [1:0] code, input logic kb);
    return (code == 2'b00) || (code == 2'b01 && kb == 1'b0) || (code == 2'b10 && kb == 1'b1);
  endfunction

  // gate=1: cells lo..hi all match; gate=0: all other cells match
  function automatic bit seg_ok(input logic [2*C-1:0] p, input logic [C-1:0] k,
                                input int hi, input int lo, input bit gate);
    bit r = 1'b1;
    for (int c = 0; c < C; c++) begin
      bit in_g = (c >= lo) && (c <= hi);
      if (in_g == gate && !cell_ok(p[2*c +: 2], k[c])) r = 1'b0;
    end
    return r;
  endfunction

  function automatic logic [2*C-1:0] gen_pat(input int s, input int w);
    logic [2*C-1:0] p;
    for (int c = 0; c < C; c++) begin
      int v = (w * 5 + c * 3 + s * 7 + w * c) % 7;
      p[2*c +: 2] = (v < 2) ? 2'b00 : (v < 4) ? 2'b01 : (v < 6) ? 2'b10 : 2'b11;
    end
    return p;
  endfunction

  task automatic do_write(input int a, input logic [2*C-1:0] p);
    wr_en = 1'b1; wr_addr = AW'(a); wr_pat = p;
    while (!rdy0) @(negedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    mem[a] = p;
  endtask

  task automatic check_result(input logic [C-1:0] k, input string tag);
    int ecnt0 = 0, ecnt1 = 0, eidx0 = 0, eidx1 = 0;
    bit ehit0 = 0, ehit1 = 0;
    for (int w = 0; w < W; w++) begin
      bit g0 = seg_ok(mem[w], k, 3, 2, 1'b1);
      bit g1 = seg_ok(mem[w], k, 2, 1, 1'b1);
      if (g0) ecnt0++;
      if (g1) ecnt1++;
      if (g0 && seg_ok(mem[w], k, 3, 2, 1'b0) && !ehit0) begin ehit0 = 1; eidx0 = w; end
      if (g1 && seg_ok(mem[w], k, 2, 1, 1'b0) && !ehit1) begin ehit1 = 1; eidx1 = w; end
    end
    chk(hit0 == ehit0, {tag, " R5 R4 R1 hit"}, hit0, ehit0);
    chk(idx0 == AW'(eidx0), {tag, " R5 idx"}, idx0, eidx0);
    chk(cnt0 == CW'(ecnt0), {tag, " R3 act_cnt"}, cnt0, ecnt0);
    chk(hit1 == ehit1 && idx1 == AW'(eidx1), {tag, " R10 hit/idx"}, {hit1, idx1}, {ehit1, AW'(eidx1)});
    chk(cnt1 == CW'(ecnt1), {tag, " R10 act_cnt"}, cnt1, ecnt1);
  endtask

  // start asserted from this negedge; done expected at the 4th later negedge
  task automatic do_search(input logic [C-1:0] k, input string tag);
    int n = 0;
    srch_start = 1'b1; srch_key = k;
    @(negedge clk); n++;
    srch_start = 1'b0;
    while (!done0 && n < 12) begin @(negedge clk); n++; end
    chk(n == 4, {tag, " R6 latency"}, n, 4);
    check_result(k, tag);
    @(negedge clk);
    chk(!done0, {tag, " R6 pulse width"}, done0, 0);
  endtask

  initial begin
    int n;
    int dcount;
    rst_n = 1'b0; wr_en = 1'b0; srch_start = 1'b0; wr_addr = '0; wr_pat = '0; srch_key = '0;
    for (int w = 0; w < W; w++) mem[w] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done0 && !hit0 && idx0 == 0 && cnt0 == 0, "R2 reset outputs", {done0, hit0, idx0, cnt0}, 0);
    chk(rdy0 == 1'b1, "R2 wr_ready after reset", rdy0, 1);
    for (int k = 0; k < 16; k++) do_search(C'(k), "R2 empty table");

    // R4: gating segment fails while suffix agrees
    do_write(2, 8'b10_10_01_01);
    do_search(4'b0000, "R4 gate miss");
    do_search(4'b1100, "R4 full match");
    do_search(4'b1111, "R4 suffix miss");
    // R8: out-of-range address is not possible at W=8; write word 0 then search immediately
    do_write(0, 8'b00_00_00_00);
    do_search(4'b1010, "R8 immediate visibility");

    // exhaustive key sweep over several tables
    for (int s = 0; s < 3; s++) begin
      for (int w = 0; w < W; w++) do_write(w, gen_pat(s, w));
      for (int k = 0; k < 16; k++) do_search(C'(k), "R1 sweep");
    end

    // R7: start kept high with another key during the search
    srch_start = 1'b1; srch_key = 4'b0110;
    @(negedge clk);
    srch_key = 4'b1001;
    @(negedge clk);
    @(negedge clk);
    srch_start = 1'b0;
    @(negedge clk);
    chk(done0, "R7 done on time", done0, 1);
    check_result(4'b0110, "R7 key kept");
    dcount = 0;
    repeat (6) begin @(negedge clk); if (done0) dcount++; end
    chk(dcount == 0, "R7 no extra done", dcount, 0);

    // R9: write and search in the same idle cycle; search sees old table
    srch_start = 1'b1; srch_key = 4'b0101;
    wr_en = 1'b1; wr_addr = 3'd0; wr_pat = 8'b01_10_01_10;
    #1;
    chk(rdy0 == 1'b0, "R9 wr_ready low on collision", rdy0, 0);
    n = 0;
    @(negedge clk); n++;
    srch_start = 1'b0;
    chk(rdy0 == 1'b0, "R9 wr_ready low while busy", rdy0, 0);
    while (!done0 && n < 12) begin @(negedge clk); n++; end
    chk(n == 4, "R9 latency", n, 4);
    check_result(4'b0101, "R9 old contents");
    while (!rdy0) @(negedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    mem[0] = 8'b01_10_01_10;
    do_search(4'b0101, "R9 stalled write landed");
    chk(hit0 && idx0 == 0, "R9 new entry hit", {hit0, idx0}, 8);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog R6 actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule